// File: doc/BRIEF.md
# I/Q Sub-band Demodulate, Filter and Remodulate Path

This block handles one band-pass branch of a parallel-band converter once its first decimation stage is done. A signed sample stream arrives with a valid strobe. Each accepted sample is mixed down to baseband by a complex rotation at the branch centre frequency. The rotation is built as two real paths: I uses the cosine and Q uses the negated sine. Both paths run through one low-pass FIR each. The two FIRs share a single coefficient set. The FIR does three jobs at once: it removes the mixing image, serves as the anti-alias filter for a decimate-by-two, and keeps only the branch band. The decimated I/Q pair is then rotated back up to the centre frequency at half the input rate. The real part of that product is emitted, so it can be added directly to the outputs of the neighbouring branches.

Two numerically controlled oscillators, one per rate, drive a shared quarter-wave sine table. The centre frequency and the input rate are parameters. A low-pass variant, used for the branch that starts at DC, bypasses both mixers and outputs the filtered in-phase path. The decimation phase is held by a two-state machine. `PH_TAKE` waits for the first sample of a pair and goes to `PH_EMIT` on an accepted sample. `PH_EMIT` waits for the second sample, and on that sample it returns to `PH_TAKE` and launches a filter output.

Top module: `iq_subband_path`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_vld` is 0 and `out_y` is 0. Both oscillator phases restart at zero, the FIR histories are cleared to zero, and the decimation state restarts in `PH_TAKE`.
- R2: For the k-th accepted input sample x (k from 0), the demodulator phase is P = k·D mod 2^24, where D = round(FC_KHZ·2^24 / IN_KHZ). With a = P[23:14] and S(a) = round(32767·sin(2π·a/1024)), the mixer gives I = floor((x·S(a+256 mod 1024) + 2^14) / 2^15) and Q = floor((−x·S(a) + 2^14) / 2^15).
- R3: One result is produced for every two accepted samples, on the second sample of each pair (`PH_TAKE`→`PH_EMIT`→`PH_TAKE`). Two results never appear on consecutive cycles.
- R4: Each filtered value is clip(floor((Σ c_k·h_k + 2^(COEF_W−2)) / 2^(COEF_W−1))). Here h_0 is the newest mixed sample. c_k is the signed field `taps_i[k·COEF_W +: COEF_W]`, shared by I and Q. The history before the first sample is zero.
- R5: For the m-th result (m from 0), the remodulator phase is m·U mod 2^24, where U = round(FC_KHZ·2^24 / (IN_KHZ/2)). With the same table and address rule as R2, `out_y` = clip(floor((I·cos − Q·sin + 2^14) / 2^15)).
- R6: Every clip is symmetric to ±(2^(DATA_W−1)−1). The value −2^(DATA_W−1) never appears on `out_y`.
- R7: `out_vld` pulses exactly three cycles after the clock edge that accepts the second sample of a pair.
- R8: `out_vld` is high for one cycle per result. While it is low, `out_y` holds its last value. Cycles without `in_vld` advance neither oscillator nor the FIR.
- R9: With `LOWPASS`=1 there is no mixing. The I history takes x unchanged, and `out_y` is the filtered I value with the same R4 arithmetic and R7 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Input sample strobe |
| in_x | input | DATA_W | Signed input sample |
| taps_i | input | NTAPS·COEF_W | Static shared FIR coefficients, tap k at bits k·COEF_W |
| out_vld | output | 1 | Result strobe at half the input rate |
| out_y | output | DATA_W | Signed real part of the remodulated sample |

## Verification
The bench builds two instances with seven taps and 16-bit data. The first is a band-pass branch at 1100 kHz on a 9000 kHz stream, so both oscillators step through many table quadrants within a few hundred samples. The second is the low-pass variant, which is compared exactly. The short filter lets the bench change the coefficients between bursts. It can then drive both FIRs and the remodulator hard into positive and negative saturation, and mix back-to-back samples with randomly gapped ones to exercise the pair boundary and the output timing.

// File: rtl/iq_band_pkg.sv
package iq_band_pkg;

    localparam int     LUT_AW  = 10;
    localparam int     QTR     = 256;
    localparam int     AMP_W   = 16;
    localparam int     FRAC    = AMP_W - 1;
    localparam longint AMP_MAX = 32767;

    typedef enum logic {PH_TAKE, PH_EMIT} dec_state_t;

    // round(AMP_MAX * sin(k*pi/512)) for k in 0..256, by a fixed-point series
    function automatic longint quarter_sine(input int k);
        longint x;
        longint term;
        longint acc;
        longint res;
        x    = (longint'(k) * 64'sd3373259426) / 512;
        term = x;
        acc  = x;
        for (int n = 1; n <= 6; n++) begin
            term = -((((term * x) >>> 30) * x) >>> 30) / longint'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        res = (acc * AMP_MAX + (64'sd1 <<< 29)) >>> 30;
        if (res > AMP_MAX) res = AMP_MAX;
        if (res < 0) res = 0;
        return res;
    endfunction

    function automatic longint round_shift(input longint v, input int s);
        return (v + (64'sd1 <<< (s - 1))) >>> s;
    endfunction

    function automatic longint clip_sym(input longint v, input int w);
        longint lim;
        lim = (64'sd1 <<< (w - 1)) - 1;
        if (v > lim)  return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

endpackage

// File: rtl/iq_sine_rom.sv
module iq_sine_rom
    import iq_band_pkg::*;
(
    input  logic [LUT_AW-1:0]       addr_i,
    output logic signed [AMP_W-1:0] sin_o,
    output logic signed [AMP_W-1:0] cos_o
);

    logic signed [AMP_W-1:0] qtab [0:QTR];

    for (genvar g = 0; g <= QTR; g++) begin : g_tab
        localparam logic signed [AMP_W-1:0] QV = AMP_W'(quarter_sine(g));
        assign qtab[g] = QV;
    end

    logic [LUT_AW-1:0] caddr;
    logic [8:0]        sidx;
    logic [8:0]        cidx;

    always_comb begin
        caddr = addr_i + LUT_AW'(QTR);
        sidx  = addr_i[8] ? (9'(QTR) - 9'(addr_i[7:0])) : 9'(addr_i[7:0]);
        cidx  = caddr[8]  ? (9'(QTR) - 9'(caddr[7:0]))  : 9'(caddr[7:0]);
        sin_o = addr_i[9] ? -qtab[sidx] : qtab[sidx];
        cos_o = caddr[9]  ? -qtab[cidx] : qtab[cidx];
    end

    longint mag2;
    always_comb begin
        mag2 = longint'(sin_o) * longint'(sin_o) + longint'(cos_o) * longint'(cos_o);
        // R2
        unit_circle_chk: assert (mag2 <= AMP_MAX * AMP_MAX + 4 * AMP_MAX &&
                                 mag2 >= AMP_MAX * AMP_MAX - 4 * AMP_MAX);
    end

endmodule

// File: rtl/iq_mixer.sv
module iq_mixer
    import iq_band_pkg::*;
#(
    parameter int                 DATA_W  = 16,
    parameter int                 PHASE_W = 24,
    parameter logic [PHASE_W-1:0] STEP    = '0,
    parameter bit                 BYPASS  = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld_i,
    input  logic signed [DATA_W-1:0] x_i,
    output logic                     vld_o,
    output logic signed [DATA_W-1:0] i_o,
    output logic signed [DATA_W-1:0] q_o
);

    if (BYPASS) begin : g_pass
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_o <= 1'b0;
                i_o   <= '0;
                q_o   <= '0;
            end else begin
                vld_o <= vld_i;
                q_o   <= '0;
                if (vld_i) i_o <= x_i;
            end
        end
    end else begin : g_mix
        logic [PHASE_W-1:0]      phase;
        logic signed [AMP_W-1:0] s_v;
        logic signed [AMP_W-1:0] c_v;

        iq_sine_rom u_rom (
            .addr_i (phase[PHASE_W-1 -: LUT_AW]),
            .sin_o  (s_v),
            .cos_o  (c_v)
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                phase <= '0;
                vld_o <= 1'b0;
                i_o   <= '0;
                q_o   <= '0;
            end else begin
                vld_o <= vld_i;
                if (vld_i) begin
                    phase <= phase + STEP;
                    i_o   <= DATA_W'(round_shift(longint'(x_i) * longint'(c_v), FRAC));
                    q_o   <= DATA_W'(round_shift(-(longint'(x_i) * longint'(s_v)), FRAC));
                end
            end
        end
    end

endmodule

// File: rtl/iq_dec_fir.sv
module iq_dec_fir
    import iq_band_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int NTAPS  = 83
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      vld_i,
    input  logic signed [DATA_W-1:0]  i_i,
    input  logic signed [DATA_W-1:0]  q_i,
    input  logic [NTAPS*COEF_W-1:0]   taps_i,
    output logic                      vld_o,
    output logic signed [DATA_W-1:0]  i_o,
    output logic signed [DATA_W-1:0]  q_o
);

    localparam int SHIFT = COEF_W - 1;

    dec_state_t state_q;
    logic       emit_q;
    logic signed [DATA_W-1:0] line_i [NTAPS];
    logic signed [DATA_W-1:0] line_q [NTAPS];
    longint acc_i;
    longint acc_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_TAKE;
        end else if (vld_i) begin
            unique case (state_q)
                PH_TAKE: state_q <= PH_EMIT;
                PH_EMIT: state_q <= PH_TAKE;
            endcase
        end
    end

    always_comb begin
        acc_i = 0;
        acc_q = 0;
        for (int k = 0; k < NTAPS; k++) begin
            acc_i = acc_i + longint'($signed(taps_i[k*COEF_W +: COEF_W])) * longint'(line_i[k]);
            acc_q = acc_q + longint'($signed(taps_i[k*COEF_W +: COEF_W])) * longint'(line_q[k]);
        end
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emit_q <= 1'b0;
            vld_o  <= 1'b0;
            i_o    <= '0;
            q_o    <= '0;
            for (int k = 0; k < NTAPS; k++) begin
                line_i[k] <= '0;
                line_q[k] <= '0;
            end
        end else begin
            emit_q <= vld_i && (state_q == PH_EMIT);
            vld_o  <= emit_q;
            if (vld_i) begin
                for (int k = NTAPS - 1; k > 0; k--) begin
                    line_i[k] <= line_i[k-1];
                    line_q[k] <= line_q[k-1];
                end
                line_i[0] <= i_i;
                line_q[0] <= q_i;
            end
            if (emit_q) begin
                i_o <= DATA_W'(clip_sym(round_shift(acc_i, SHIFT), DATA_W));
                q_o <= DATA_W'(clip_sym(round_shift(acc_q, SHIFT), DATA_W));
            end
        end
    end

    // R3
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o);
    // R3
    emit_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> $past(vld_i, 2));

endmodule

// File: rtl/iq_remod.sv
module iq_remod
    import iq_band_pkg::*;
#(
    parameter int                 DATA_W  = 16,
    parameter int                 PHASE_W = 24,
    parameter logic [PHASE_W-1:0] STEP    = '0,
    parameter bit                 BYPASS  = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld_i,
    input  logic signed [DATA_W-1:0] i_i,
    input  logic signed [DATA_W-1:0] q_i,
    output logic                     vld_o,
    output logic signed [DATA_W-1:0] y_o
);

    if (BYPASS) begin : g_pass
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_o <= 1'b0;
                y_o   <= '0;
            end else begin
                vld_o <= vld_i;
                if (vld_i) y_o <= i_i;
            end
        end
    end else begin : g_rot
        logic [PHASE_W-1:0]      phase;
        logic signed [AMP_W-1:0] s_v;
        logic signed [AMP_W-1:0] c_v;
        longint                  mix;

        iq_sine_rom u_rom (
            .addr_i (phase[PHASE_W-1 -: LUT_AW]),
            .sin_o  (s_v),
            .cos_o  (c_v)
        );

        assign mix = longint'(i_i) * longint'(c_v) - longint'(q_i) * longint'(s_v);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                phase <= '0;
                vld_o <= 1'b0;
                y_o   <= '0;
            end else begin
                vld_o <= vld_i;
                if (vld_i) begin
                    phase <= phase + STEP;
                    y_o   <= DATA_W'(clip_sym(round_shift(mix, FRAC), DATA_W));
                end
            end
        end
    end

    // R6
    no_most_negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (y_o != {1'b1, {(DATA_W-1){1'b0}}}));
    // R8
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> $stable(y_o));

endmodule

// File: rtl/iq_subband_path.sv
module iq_subband_path
    import iq_band_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int COEF_W  = 16,
    parameter int NTAPS   = 83,
    parameter int PHASE_W = 24,
    parameter int FC_KHZ  = 1100,
    parameter int IN_KHZ  = 9000,
    parameter bit LOWPASS = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic signed [DATA_W-1:0] in_x,
    input  logic [NTAPS*COEF_W-1:0]  taps_i,
    output logic                     out_vld,
    output logic signed [DATA_W-1:0] out_y
);

    localparam int     OUT_KHZ = IN_KHZ / 2;
    localparam longint PH_ONE  = 64'sd1 <<< PHASE_W;
    localparam logic [PHASE_W-1:0] DEMOD_STEP =
        PHASE_W'((longint'(FC_KHZ) * PH_ONE + longint'(IN_KHZ / 2)) / longint'(IN_KHZ));
    localparam logic [PHASE_W-1:0] REMOD_STEP =
        PHASE_W'((longint'(FC_KHZ) * PH_ONE + longint'(OUT_KHZ / 2)) / longint'(OUT_KHZ));

    logic                     m_vld;
    logic signed [DATA_W-1:0] m_i;
    logic signed [DATA_W-1:0] m_q;
    logic                     f_vld;
    logic signed [DATA_W-1:0] f_i;
    logic signed [DATA_W-1:0] f_q;

    iq_mixer #(
        .DATA_W (DATA_W), .PHASE_W (PHASE_W), .STEP (DEMOD_STEP), .BYPASS (LOWPASS)
    ) u_mix (
        .clk (clk), .rst_n (rst_n), .vld_i (in_vld), .x_i (in_x),
        .vld_o (m_vld), .i_o (m_i), .q_o (m_q)
    );

    iq_dec_fir #(
        .DATA_W (DATA_W), .COEF_W (COEF_W), .NTAPS (NTAPS)
    ) u_fir (
        .clk (clk), .rst_n (rst_n), .vld_i (m_vld), .i_i (m_i), .q_i (m_q),
        .taps_i (taps_i), .vld_o (f_vld), .i_o (f_i), .q_o (f_q)
    );

    iq_remod #(
        .DATA_W (DATA_W), .PHASE_W (PHASE_W), .STEP (REMOD_STEP), .BYPASS (LOWPASS)
    ) u_rem (
        .clk (clk), .rst_n (rst_n), .vld_i (f_vld), .i_i (f_i), .q_i (f_q),
        .vld_o (out_vld), .y_o (out_y)
    );

    // R7
    out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(f_vld));
    // R9
    lowpass_no_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (LOWPASS && f_vld) |-> (f_q == '0));

endmodule

// File: tb/iq_subband_path_tb.sv
module iq_subband_path_tb;

    localparam int DW  = 16;
    localparam int CW  = 16;
    localparam int NT  = 7;
    localparam int FC  = 1100;
    localparam int FIN = 9000;
    localparam longint MASK = (64'sd1 <<< 24) - 1;
    localparam longint DSTEP = (longint'(FC) * (64'sd1 <<< 24) + FIN / 2) / FIN;
    localparam longint RSTEP = (longint'(FC) * (64'sd1 <<< 24) + FIN / 4) / (FIN / 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0;
    logic signed [DW-1:0] in_x = '0;
    logic [NT*CW-1:0] taps = '0;
    logic bp_vld, lp_vld;
    logic signed [DW-1:0] bp_y, lp_y;

    always #5 clk = ~clk;

    iq_subband_path #(.DATA_W(DW), .COEF_W(CW), .NTAPS(NT), .FC_KHZ(FC),
                      .IN_KHZ(FIN), .LOWPASS(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_x(in_x), .taps_i(taps),
        .out_vld(bp_vld), .out_y(bp_y));

    iq_subband_path #(.DATA_W(DW), .COEF_W(CW), .NTAPS(NT), .FC_KHZ(FC),
                      .IN_KHZ(FIN), .LOWPASS(1'b1)) u_dut_lp (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_x(in_x), .taps_i(taps),
        .out_vld(lp_vld), .out_y(lp_y));

    typedef struct { longint v; int due; } exp_t;
    exp_t qbp[$];
    exp_t qlp[$];

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int nacc = 0;
    int seen_bp = 0;
    int seen_lp = 0;
    bit run = 1'b0;
    bit done = 1'b0;
    longint stab [1024];
    longint ctap [NT];
    longint hbi [NT];
    longint hbq [NT];
    longint hli [NT];
    longint pd = 0;
    longint pr = 0;
    longint last_bp = 0;
    longint last_lp = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint rs(input longint v);
        return (v + 16384) >>> 15;
    endfunction

    function automatic longint clp(input longint v);
        if (v > 32767) return 32767;
        if (v < -32767) return -32767;
        return v;
    endfunction

    task automatic set_tap(input int k, input int v);
        ctap[k] = v;
        taps[k*CW +: CW] = CW'(v);
    endtask

    task automatic model(input longint x);
        int a;
        longint mi, mq, fi, fq, fl, y;
        exp_t e;
        a  = int'(pd >>> 14);
        mi = rs(x * stab[(a + 256) % 1024]);
        mq = rs(-(x * stab[a]));
        pd = (pd + DSTEP) & MASK;
        for (int k = NT - 1; k > 0; k--) begin
            hbi[k] = hbi[k-1]; hbq[k] = hbq[k-1]; hli[k] = hli[k-1];
        end
        hbi[0] = mi; hbq[0] = mq; hli[0] = x;
        nacc++;
        if (nacc % 2 == 0) begin
            fi = 0; fq = 0; fl = 0;
            for (int k = 0; k < NT; k++) begin
                fi += ctap[k] * hbi[k];
                fq += ctap[k] * hbq[k];
                fl += ctap[k] * hli[k];
            end
            fi = clp(rs(fi)); fq = clp(rs(fq)); fl = clp(rs(fl));
            a  = int'(pr >>> 14);
            y  = clp(rs(fi * stab[(a + 256) % 1024] - fq * stab[a]));
            pr = (pr + RSTEP) & MASK;
            e.due = cyc + 4;
            e.v = y;  qbp.push_back(e);
            e.v = fl; qlp.push_back(e);
        end
    endtask

    task automatic send(input int x, input int gap);
        in_vld = 1'b1;
        in_x   = DW'(x);
        model(longint'(x));
        @(negedge clk);
        in_vld = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (run) begin
            if (bp_vld) begin
                seen_bp++;
                if (qbp.size() == 0) check(1'b0, "R3 unexpected band-pass result", bp_y, 0);
                else begin
                    exp_t e;
                    e = qbp.pop_front();
                    check((longint'(bp_y) - e.v <= 3) && (e.v - longint'(bp_y) <= 3),
                          "R2 R4 R5 band-pass value", bp_y, e.v);
                    check(cyc == e.due, "R7 band-pass timing", cyc, e.due);
                end
                check(bp_y != -32768, "R6 band-pass range", bp_y, -32767);
                last_bp = bp_y;
            end else begin
                if (qbp.size() != 0 && qbp[0].due <= cyc)
                    check(1'b0, "R7 band-pass result missing", 0, qbp[0].due);
                check(longint'(bp_y) == last_bp, "R8 band-pass hold", bp_y, last_bp);
            end
            if (lp_vld) begin
                seen_lp++;
                if (qlp.size() == 0) check(1'b0, "R3 unexpected low-pass result", lp_y, 0);
                else begin
                    exp_t e;
                    e = qlp.pop_front();
                    check(longint'(lp_y) == e.v, "R9 R4 low-pass value", lp_y, e.v);
                    check(cyc == e.due, "R7 low-pass timing", cyc, e.due);
                end
                check(lp_y != -32768, "R6 low-pass range", lp_y, -32767);
                last_lp = lp_y;
            end else begin
                check(longint'(lp_y) == last_lp, "R8 low-pass hold", lp_y, last_lp);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL R3 watchdog: run still busy at cycle %0d, expected end before 20000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 1024; a++) begin
            real v;
            v = 32767.0 * $sin(2.0 * 3.14159265358979 * a / 1024.0);
            stab[a] = (v >= 0.0) ? longint'($rtoi(v + 0.5)) : -longint'($rtoi(-v + 0.5));
        end
        for (int k = 0; k < NT; k++) begin
            hbi[k] = 0; hbq[k] = 0; hli[k] = 0; ctap[k] = 0;
        end
        set_tap(0, 1000); set_tap(1, 3000); set_tap(2, 6000); set_tap(3, 8000);
        set_tap(4, 6000); set_tap(5, 3000); set_tap(6, 1000);

        repeat (4) @(negedge clk);
        // R1 reset state
        check(bp_vld == 1'b0, "R1 band-pass valid in reset", bp_vld, 0);
        check(bp_y == '0, "R1 band-pass output in reset", bp_y, 0);
        check(lp_vld == 1'b0, "R1 low-pass valid in reset", lp_vld, 0);
        check(lp_y == '0, "R1 low-pass output in reset", lp_y, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bp_vld == 1'b0 && bp_y == '0, "R1 band-pass after reset", bp_y, 0);
        run = 1'b1;

        // impulse then tone-like ramp, back-to-back samples
        send(20000, 0);
        for (int n = 0; n < 15; n++) send(0, 0);
        for (int n = 0; n < 40; n++) send((n % 8) * 4000 - 14000, 0);
        repeat (6) @(negedge clk);

        // randomly gapped samples (R8: gaps advance nothing)
        for (int n = 0; n < 80; n++)
            send(int'($urandom_range(40000)) - 20000, int'($urandom_range(3)));
        repeat (8) @(negedge clk);

        // saturation in both directions (R6)
        for (int k = 0; k < NT; k++) set_tap(k, 30000);
        for (int n = 0; n < 14; n++) send(32000, 0);
        for (int n = 0; n < 14; n++) send(-32000, n % 2);
        for (int n = 0; n < 10; n++) send(-32768, 0);
        repeat (8) @(negedge clk);

        // negative coefficients, odd count leaves a half pair pending
        for (int k = 0; k < NT; k++) set_tap(k, (k % 2 == 0) ? -5000 : 7000);
        for (int n = 0; n < 21; n++) send(n * 1500 - 15000, 1);
        repeat (12) @(negedge clk);

        // R3 one result per two accepted samples
        check(seen_bp == nacc / 2, "R3 band-pass result count", seen_bp, nacc / 2);
        check(seen_lp == nacc / 2, "R3 low-pass result count", seen_lp, nacc / 2);
        check(qbp.size() == 0 && qlp.size() == 0, "R3 results outstanding",
              qbp.size() + qlp.size(), 0);

        done = 1'b1;
        run = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule